// File: doc/BRIEF.md
# CAN Reset-Request and Bus-Integration Sequencer

This block owns the reset-request flag of a CAN protocol controller. The flag is raised in three ways: by an external reset, by a CPU write to the control register, or by the protocol engine reporting bus-off. While the flag is set, the frame engine is told to abandon whatever frame it is handling. CPU writes to the command register are refused, and the acceptance filter, the two bit-timing registers and the output-control register become writable.

Only the CPU can clear the flag. Once it is clear, the block watches the sampled bus, one recessive or dominant indication per bit time. It counts runs of eleven consecutive recessive bits. After an external or CPU request, one such run is enough before `ready_o` lets the controller join the bus. After a bus-off request, 128 runs are needed, a count that is kept across dominant bits.

The block also drives a hold signal for the error counters while a CPU-raised request is in force, so such a request does not disturb them. A small byte-wide register port gives the CPU access to the control, command and configuration registers.

Top module: `can_rstreq_seq`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `rr_o` is 1, `ready_o` is 0, `err_hold_o` is 0 and the control register reads 0x01.
- R2: When the reset request goes from clear to set (CPU write or bus-off), `abort_o` is high for exactly the one cycle after the setting edge, and `ready_o` is 0 in that cycle.
- R3: A cycle with `bus_off_i` high sets the request and records bus-off as its source. This holds even when the CPU writes 0 to the control register in the same cycle.
- R4: The block never clears the request by itself. Any number of recessive bits leaves `rr_o` at 1 until the CPU writes 0 to control bit 0.
- R5: After clearing an external- or CPU-raised request, `ready_o` rises in the cycle after the 11th consecutive recessive bit tick.
- R6: After clearing a bus-off-raised request, `ready_o` rises only after 128 completed runs of 11 consecutive recessive bit ticks.
- R7: A dominant bit tick (`bit_rx_i`=0 with `bit_tick_i`=1) restarts the current run at zero, but completed runs are kept.
- R8: `err_hold_o` is 1 exactly while the request is set and its recorded source is the CPU.
- R9: The command register (address 1) is write-only, and every read of it returns 0xFF.
- R10: A command write is taken only while the request is clear. It then gives a one-cycle `cmd_wr_o` pulse with `cmd_data_o` equal to the written byte. Command writes made while the request is set produce no pulse.
- R11: Configuration registers are at addresses 2 (acceptance code), 3 (acceptance mask), 4 (bit timing 0), 5 (bit timing 1) and 6 (output control). They can be written and read back only while the request is set. While it is clear, writes are ignored and reads return 0x00.
- R12: The control register is at address 0. On a write, bit 0 = 1 raises the request and bit 0 = 0 clears it. On a read, bit 0 is the request, bit 1 is 1 when the recorded source is bus-off, and bit 2 is `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset; raises the request |
| bus_off_i | input | 1 | Bus-off report from the protocol engine, one cycle per event |
| bit_tick_i | input | 1 | One-cycle strobe per sampled bit time |
| bit_rx_i | input | 1 | Sampled bus level at the tick: 1 recessive, 0 dominant |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_addr_i | input | 3 | CPU register address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, combinational on the address |
| rr_o | output | 1 | Reset request currently set |
| abort_o | output | 1 | One-cycle pulse that aborts the frame in progress |
| err_hold_o | output | 1 | Hold error counter values |
| ready_o | output | 1 | Normal bus operation may resume |
| cmd_wr_o | output | 1 | Accepted command write pulse |
| cmd_data_o | output | 8 | Byte of the accepted command write |
| acc_code_o | output | 8 | Acceptance code value |
| acc_mask_o | output | 8 | Acceptance mask value |
| btim0_o | output | 8 | Bit-timing register 0 value |
| btim1_o | output | 8 | Bit-timing register 1 value |
| outctl_o | output | 8 | Output-control value |

## Verification
The assertions take for granted that `bus_off_i` and CPU writes are single-cycle events and that `bit_tick_i` is a strobe whose `bit_rx_i` value is valid in the same cycle. The bench keeps to this. It drives every input on the falling edge and holds each write and bus-off for one cycle. It raises at most one bit tick per cycle. The only case where a bus-off and a CPU clear occur together is the deliberate priority case.

// File: rtl/can_rr_pkg.sv
package can_rr_pkg;
   typedef enum logic [1:0] {
      SRC_EXT    = 2'd0,
      SRC_CPU    = 2'd1,
      SRC_BUSOFF = 2'd2
   } rr_src_e;

   localparam int ADDR_W = 3;
   localparam int NCFG   = 5;

   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
   localparam logic [ADDR_W-1:0] A_CMD    = 3'd1;
   localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd2;
endpackage

// File: rtl/can_rr_ctrl.sv
module can_rr_ctrl
   import can_rr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cpu_set_i,
   input  logic    cpu_clr_i,
   input  logic    bus_off_i,
   output logic    rr_o,
   output rr_src_e src_o,
   output logic    abort_o,
   output logic    hold_o
);
   logic    rr_q, rr_d, rr_prev_q;
   rr_src_e src_q, src_d;

   always_comb begin
      rr_d  = rr_q;
      src_d = src_q;
      if (cpu_set_i && !rr_q) begin
         rr_d  = 1'b1;
         src_d = SRC_CPU;
      end else if (cpu_clr_i) begin
         rr_d  = 1'b0;
      end
      if (bus_off_i) begin
         rr_d  = 1'b1;
         src_d = SRC_BUSOFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q      <= 1'b1;
         rr_prev_q <= 1'b1;
         src_q     <= SRC_EXT;
      end else begin
         rr_q      <= rr_d;
         rr_prev_q <= rr_q;
         src_q     <= src_d;
      end
   end

   assign rr_o    = rr_q;
   assign src_o   = src_q;
   assign abort_o = rr_q & ~rr_prev_q;
   assign hold_o  = rr_q && (src_q == SRC_CPU);

   a_r2_abort_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!rr_q && (cpu_set_i || bus_off_i)) |=> abort_o);
   a_r2_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);
   a_r3_busoff_wins: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off_i |=> (rr_q && src_q == SRC_BUSOFF));
   a_r4_no_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_q && !cpu_clr_i) |=> rr_q);
endmodule

// File: rtl/can_rr_runcnt.sv
module can_rr_runcnt #(
   parameter int RUN_LEN    = 11,
   parameter int OCC_BUSOFF = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rr_i,
   input  logic busoff_src_i,
   input  logic tick_i,
   input  logic recessive_i,
   output logic ready_o
);
   localparam int RUN_W = $clog2(RUN_LEN);
   localparam int OCC_W = $clog2(OCC_BUSOFF + 1);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("RUN_LEN must be at least 2");
   end
   if (OCC_BUSOFF < 1) begin : g_bad_occ
      $error("OCC_BUSOFF must be at least 1");
   end

   logic [RUN_W-1:0] run_q;
   logic [OCC_W-1:0] occ_q, target;

   assign target = busoff_src_i ? OCC_W'(OCC_BUSOFF) : OCC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         occ_q <= '0;
      end else if (rr_i) begin
         run_q <= '0;
         occ_q <= '0;
      end else if (tick_i && (occ_q < target)) begin
         if (!recessive_i) begin
            run_q <= '0;
         end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
            run_q <= '0;
            occ_q <= occ_q + OCC_W'(1);
         end else begin
            run_q <= run_q + RUN_W'(1);
         end
      end
   end

   assign ready_o = !rr_i && (occ_q >= target);

   a_r7_dominant_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (!rr_i && tick_i && !recessive_i) |=> (run_q == '0));
   a_r6_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q <= OCC_W'(OCC_BUSOFF)));
   a_r5_ready_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> !rr_i);
endmodule

// File: rtl/can_rr_regport.sv
module can_rr_regport
   import can_rr_pkg::*;
#(
   parameter int               W       = 8,
   parameter logic [W-1:0]     CFG_RST = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rr_i,
   input  logic                    busoff_src_i,
   input  logic                    ready_i,
   input  logic                    cpu_wr_i,
   input  logic [ADDR_W-1:0]       cpu_addr_i,
   input  logic [W-1:0]            cpu_wdata_i,
   output logic [W-1:0]            cpu_rdata_o,
   output logic                    cpu_set_o,
   output logic                    cpu_clr_o,
   output logic                    cmd_wr_o,
   output logic [W-1:0]            cmd_data_o,
   output logic [NCFG-1:0][W-1:0]  cfg_o
);
   if (W < 3) begin : g_bad_w
      $error("W must hold the three control bits");
   end

   logic wr_ctrl, wr_cmd;
   assign wr_ctrl   = cpu_wr_i && (cpu_addr_i == A_CTRL);
   assign wr_cmd    = cpu_wr_i && (cpu_addr_i == A_CMD);
   assign cpu_set_o = wr_ctrl &&  cpu_wdata_i[0];
   assign cpu_clr_o = wr_ctrl && !cpu_wdata_i[0];

   for (genvar k = 0; k < NCFG; k++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = A_CFG_LO + ADDR_W'(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_o[k] <= CFG_RST;
         else if (cpu_wr_i && rr_i && (cpu_addr_i == MY_ADDR))
            cfg_o[k] <= cpu_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_wr_o   <= 1'b0;
         cmd_data_o <= '0;
      end else begin
         cmd_wr_o <= wr_cmd && !rr_i;
         if (wr_cmd && !rr_i)
            cmd_data_o <= cpu_wdata_i;
      end
   end

   always_comb begin
      cpu_rdata_o = '0;
      if (cpu_addr_i == A_CTRL) begin
         cpu_rdata_o[0] = rr_i;
         cpu_rdata_o[1] = busoff_src_i;
         cpu_rdata_o[2] = ready_i;
      end else if (cpu_addr_i == A_CMD) begin
         cpu_rdata_o = '1;
      end else if (rr_i && (cpu_addr_i >= A_CFG_LO) &&
                   (cpu_addr_i < A_CFG_LO + ADDR_W'(NCFG))) begin
         cpu_rdata_o = cfg_o[cpu_addr_i - A_CFG_LO];
      end
   end

   a_r10_cmd_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && rr_i) |=> !cmd_wr_o);
   a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_i |=> $stable(cfg_o));
endmodule

// File: rtl/can_rstreq_seq.sv
module can_rstreq_seq
   import can_rr_pkg::*;
#(
   parameter int RUN_LEN    = 11,
   parameter int OCC_BUSOFF = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_off_i,
   input  logic       bit_tick_i,
   input  logic       bit_rx_i,
   input  logic       cpu_wr_i,
   input  logic [2:0] cpu_addr_i,
   input  logic [7:0] cpu_wdata_i,
   output logic [7:0] cpu_rdata_o,
   output logic       rr_o,
   output logic       abort_o,
   output logic       err_hold_o,
   output logic       ready_o,
   output logic       cmd_wr_o,
   output logic [7:0] cmd_data_o,
   output logic [7:0] acc_code_o,
   output logic [7:0] acc_mask_o,
   output logic [7:0] btim0_o,
   output logic [7:0] btim1_o,
   output logic [7:0] outctl_o
);
   localparam int W = 8;

   rr_src_e             src;
   logic                cpu_set, cpu_clr, busoff_src;
   logic [NCFG-1:0][W-1:0] cfg;

   can_rr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_set_i (cpu_set),
      .cpu_clr_i (cpu_clr),
      .bus_off_i (bus_off_i),
      .rr_o      (rr_o),
      .src_o     (src),
      .abort_o   (abort_o),
      .hold_o    (err_hold_o)
   );

   assign busoff_src = (src == SRC_BUSOFF);

   can_rr_runcnt #(.RUN_LEN(RUN_LEN), .OCC_BUSOFF(OCC_BUSOFF)) u_run (
      .clk          (clk),
      .rst_n        (rst_n),
      .rr_i         (rr_o),
      .busoff_src_i (busoff_src),
      .tick_i       (bit_tick_i),
      .recessive_i  (bit_rx_i),
      .ready_o      (ready_o)
   );

   can_rr_regport #(.W(W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .rr_i         (rr_o),
      .busoff_src_i (busoff_src),
      .ready_i      (ready_o),
      .cpu_wr_i     (cpu_wr_i),
      .cpu_addr_i   (cpu_addr_i),
      .cpu_wdata_i  (cpu_wdata_i),
      .cpu_rdata_o  (cpu_rdata_o),
      .cpu_set_o    (cpu_set),
      .cpu_clr_o    (cpu_clr),
      .cmd_wr_o     (cmd_wr_o),
      .cmd_data_o   (cmd_data_o),
      .cfg_o        (cfg)
   );

   assign acc_code_o = cfg[0];
   assign acc_mask_o = cfg[1];
   assign btim0_o    = cfg[2];
   assign btim1_o    = cfg[3];
   assign outctl_o   = cfg[4];

   a_r8_hold_only_in_rr: assert property (@(posedge clk) disable iff (!rst_n)
      err_hold_o |-> rr_o);
endmodule

// File: tb/can_rstreq_seq_tb.sv
module can_rstreq_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RUN        = 11;
   localparam int OCC        = 128;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_off_i = 1'b0, bit_tick_i = 1'b0, bit_rx_i = 1'b1;
   logic       cpu_wr_i = 1'b0;
   logic [2:0] cpu_addr_i = '0;
   logic [7:0] cpu_wdata_i = '0;
   logic [7:0] cpu_rdata_o, cmd_data_o;
   logic [7:0] acc_code_o, acc_mask_o, btim0_o, btim1_o, outctl_o;
   logic       rr_o, abort_o, err_hold_o, ready_o, cmd_wr_o;

   int errors = 0, checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_rstreq_seq dut_i (
      .clk(clk), .rst_n(rst_n), .bus_off_i(bus_off_i),
      .bit_tick_i(bit_tick_i), .bit_rx_i(bit_rx_i),
      .cpu_wr_i(cpu_wr_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
      .cpu_rdata_o(cpu_rdata_o), .rr_o(rr_o), .abort_o(abort_o),
      .err_hold_o(err_hold_o), .ready_o(ready_o), .cmd_wr_o(cmd_wr_o),
      .cmd_data_o(cmd_data_o), .acc_code_o(acc_code_o), .acc_mask_o(acc_mask_o),
      .btim0_o(btim0_o), .btim1_o(btim1_o), .outctl_o(outctl_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
      cpu_addr_i  = a;
      cpu_wdata_i = d;
      cpu_wr_i    = 1'b1;
      @(negedge clk);
      cpu_wr_i    = 1'b0;
   endtask

   task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
      cpu_addr_i = a;
      #1;
      d = cpu_rdata_o;
   endtask

   task automatic send_bits(input int n, input logic rec);
      for (int i = 0; i < n; i++) begin
         bit_tick_i = 1'b1;
         bit_rx_i   = rec;
         @(negedge clk);
      end
      bit_tick_i = 1'b0;
      bit_rx_i   = 1'b1;
   endtask

   function automatic logic [7:0] cfg_out(input int k);
      case (k)
         0: return acc_code_o;
         1: return acc_mask_o;
         2: return btim0_o;
         3: return btim1_o;
         default: return outctl_o;
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 rr", rr_o, 1);
      chk("R1 ready", ready_o, 0);
      chk("R1 hold", err_hold_o, 0);
      cpu_read(3'd0, rd); chk("R1 R12 ctrl", rd, 8'h01);

      // R11 configuration sweep while request set
      for (int k = 0; k < 5; k++) cpu_write(3'(2 + k), 8'(8'h11 * (k + 1)));
      for (int k = 0; k < 5; k++) begin
         cpu_read(3'(2 + k), rd);
         chk("R11 cfg readback", rd, 8'(8'h11 * (k + 1)));
         chk("R11 cfg output", cfg_out(k), 8'(8'h11 * (k + 1)));
      end
      cpu_read(3'd7, rd); chk("R11 unused addr", rd, 8'h00);

      // R10 command refused, R9 read value
      cpu_write(3'd1, 8'hA5);
      chk("R10 cmd refused", cmd_wr_o, 0);
      cpu_read(3'd1, rd); chk("R9 cmd read set", rd, 8'hFF);

      // clear request: external source, single run
      cpu_write(3'd0, 8'h00);
      chk("R12 rr cleared", rr_o, 0);
      cpu_read(3'd0, rd); chk("R12 ctrl clear", rd, 8'h00);
      send_bits(10, 1'b1);
      chk("R5 ready before 11", ready_o, 0);
      send_bits(1, 1'b0);
      send_bits(10, 1'b1);
      chk("R7 restart after dominant", ready_o, 0);
      send_bits(1, 1'b1);
      chk("R5 ready after 11", ready_o, 1);
      cpu_read(3'd0, rd); chk("R12 ctrl ready", rd, 8'h04);

      // R11 locked while clear
      cpu_write(3'd2, 8'h5A);
      chk("R11 write ignored", acc_code_o, 8'h11);
      cpu_read(3'd2, rd); chk("R11 read zero", rd, 8'h00);

      // R10 command accepted
      cpu_write(3'd1, 8'h3C);
      chk("R10 cmd pulse", cmd_wr_o, 1);
      chk("R10 cmd data", cmd_data_o, 8'h3C);
      @(negedge clk);
      chk("R10 pulse single", cmd_wr_o, 0);
      cpu_read(3'd1, rd); chk("R9 cmd read clear", rd, 8'hFF);

      // CPU raises request
      cpu_write(3'd0, 8'h01);
      chk("R2 abort cpu", abort_o, 1);
      chk("R2 ready drop", ready_o, 0);
      chk("R8 hold cpu", err_hold_o, 1);
      @(negedge clk);
      chk("R2 abort one cycle", abort_o, 0);

      // bus-off together with CPU clear
      bus_off_i = 1'b1;
      cpu_write(3'd0, 8'h00);
      bus_off_i = 1'b0;
      cpu_read(3'd0, rd); chk("R3 busoff wins", rd, 8'h03);
      chk("R8 hold busoff", err_hold_o, 0);

      // R4 never self-clears
      send_bits(30, 1'b1);
      chk("R4 rr stays", rr_o, 1);
      chk("R4 not ready", ready_o, 0);

      // bus-off recovery with mid-run dominant
      cpu_write(3'd0, 8'h00);
      cpu_read(3'd0, rd); chk("R12 busoff src kept", rd, 8'h02);
      send_bits(5, 1'b1);
      send_bits(1, 1'b0);
      send_bits(RUN * 2, 1'b1);
      chk("R6 not ready after 2 runs", ready_o, 0);
      send_bits(4, 1'b1);
      send_bits(1, 1'b0);
      send_bits(RUN * (OCC - 2) - 1, 1'b1);
      chk("R7 R6 one bit short", ready_o, 0);
      send_bits(1, 1'b1);
      chk("R6 ready after 128 runs", ready_o, 1);
      cpu_read(3'd0, rd); chk("R12 ctrl busoff ready", rd, 8'h06);

      // bus-off from normal operation
      bus_off_i = 1'b1;
      @(negedge clk);
      bus_off_i = 1'b0;
      chk("R2 abort busoff", abort_o, 1);
      chk("R3 rr busoff", rr_o, 1);
      chk("R2 ready off", ready_o, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule